// File: doc/BRIEF.md
# Eight-Channel DAC Control Core

This block is the digital control core of an eight-channel voltage-output converter. A three-wire serial port delivers 32-bit command frames. The core decodes each frame and performs one action: it writes channel input registers, moves them into the DAC registers, programs per-channel power-down modes, selects the code used by the clear input, sets the mask for the hardware load strobe, or switches the internal reference on or off. Its outputs drive the digital side of the analog strings, buffers and reference.

Every channel is double-buffered. The input register holds a pending code, and only the DAC register drives the channel's output code. Channels 0 to 3 resolve 16 bits. Channels 4 to 7 resolve 12 bits. An active-low hardware load input moves pending codes into the DAC registers of all channels enabled in the load mask, all on the same edge. An active-low clear input forces every DAC register to a programmable code.

The serial lines are oversampled by the core clock, so the clock must run at least four times faster than the serial clock. All actions take effect on the second rising clock edge after the core samples the triggering input change.

Top module: `octal_dac_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, every channel code is 0, every power-down field is 00 and `ref_en` is 0. The load mask resets to all ones. The clear selection resets to zero scale.
- R2: A frame is shifted in MSB first. Each bit is taken on a falling `sck` edge while `cs_n` is low. The frame is executed only if exactly 32 bits arrived before `cs_n` rises. Frames of 31 or 33 bits change nothing. Bit layout: [27:24] command, [23:20] address, [19:4] data. Bits [31:28] and [3:0] are ignored.
- R3: Command 0 writes input registers and leaves the output codes unchanged. Command 1 copies the addressed input register into its DAC register.
- R4: Command 3 writes the addressed channel's input and DAC registers with the data. Command 2 writes the addressed input register, then loads every channel's DAC register from its (new) input register.
- R5: Address 15 selects all channels for commands 0 to 3. Addresses 8 to 14 select no channel.
- R6: Channels 4 to 7 take data bits [15:4]. Their output code appears in bits [11:0] of the channel's 16-bit output field, and bits [15:12] read 0. Channel c occupies `dac_code[16c+15:16c]`.
- R7: Command 6 loads the mask from data[7:0], with bit c enabling channel c. While `hw_load_n` is low, every enabled channel's DAC register takes its input register. Masked-off channels keep their codes.
- R8: Command 5 selects the clear code from data[1:0]: 00 or 11 gives zero, 01 gives midscale, 10 gives full scale. Midscale is 0x8000 for 16-bit channels and 0x800 for 12-bit channels. Full scale is 0xFFFF and 0xFFF. While `clear_n` is low, every DAC register is loaded with that code. The DAC registers keep the code after release. Input registers are untouched.
- R9: Command 4 sets the power-down modes from data[15:0], with channel c at bits [2c+1:2c]. Mode 00 is normal operation; 01, 10 and 11 are three power-down modes.
- R10: Command 7 sets `ref_en` to data[0].
- R11: Commands 8 to 15 change nothing.
- R12: Output changes caused by a frame end, the load strobe or the clear input appear on the second rising `clk` edge after the core first samples the input change, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial port |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock; data is taken on its falling edge |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| hw_load_n | input | 1 | Active-low hardware load strobe (level sensitive) |
| clear_n | input | 1 | Active-low clear to the programmed code |
| dac_code | output | 128 | Eight 16-bit channel code fields, channel 0 in the low bits |
| pd_mode | output | 16 | Eight 2-bit power-down modes, channel 0 in the low bits |
| ref_en | output | 1 | Internal reference enable |

## Verification
The bench sends frames of 31 and 33 bits. A core that counts bits loosely would execute them and overwrite channel 2. It writes through the reserved addresses 8 to 14, where a careless decode would alias them onto real channels. It sends undefined command codes, which a decoder with a catch-all branch might treat as a write. It writes 12-bit channels with data whose low nibble is set. A core that sliced the wrong bits would show a shifted or truncated code. It pulses the load strobe under a partial mask, which exposes a core that updates every channel. It checks the clear code on both channel widths and then confirms that an update restores the untouched input registers. It checks that a clear has no effect after one edge and has taken effect after two, so a core with a missing or extra pipeline stage fails.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int CODE_W   = 16;
    localparam int NARROW_W = 12;
    localparam int FRAME_W  = 32;
    localparam int ADDR_W   = 4;
    localparam int PD_W     = 2;
    localparam int CNT_W    = $clog2(FRAME_W + 2);

    localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;

    typedef enum logic [3:0] {
        OP_WRITE_IN   = 4'd0,
        OP_UPDATE     = 4'd1,
        OP_WRITE_ALL  = 4'd2,
        OP_WRITE_UPD  = 4'd3,
        OP_POWER      = 4'd4,
        OP_CLEAR_SEL  = 4'd5,
        OP_LOAD_MASK  = 4'd6,
        OP_REFERENCE  = 4'd7
    } dac_op_e;

    typedef enum logic [1:0] {
        CLR_ZERO = 2'd0,
        CLR_MID  = 2'd1,
        CLR_FULL = 2'd2,
        CLR_ALT0 = 2'd3
    } clr_sel_e;

    typedef struct packed {
        logic [3:0]        pad_hi;
        logic [3:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] data;
        logic [3:0]        pad_lo;
    } frame_t;

    function automatic logic [CODE_W-1:0] clear_value(clr_sel_e sel, logic wide);
        logic [CODE_W-1:0] v;
        case (sel)
            CLR_MID:  v = wide ? 16'h8000 : 16'h0800;
            CLR_FULL: v = wide ? 16'hFFFF : 16'h0FFF;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
    import dac_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck,
    input  logic   cs_n,
    input  logic   sdi,
    output logic   frm_valid,
    output frame_t frm
);

    logic [1:0]         sck_q;
    logic [1:0]         cs_q;
    logic               sdi_q;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   nbits;
    logic               sck_fall;

    assign sck_fall = sck_q[1] & ~sck_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            cs_q  <= 2'b11;
            sdi_q <= 1'b0;
            shreg <= '0;
            nbits <= '0;
        end else begin
            sck_q <= {sck_q[0], sck};
            cs_q  <= {cs_q[0], cs_n};
            sdi_q <= sdi;
            if (cs_q[0]) begin
                nbits <= '0;
            end else if (sck_fall) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_q};
                if (nbits != CNT_W'(FRAME_W + 1))
                    nbits <= nbits + 1'b1;
            end
        end
    end

    assign frm_valid = ~cs_q[1] & cs_q[0] & (nbits == CNT_W'(FRAME_W));
    assign frm       = frame_t'(shreg);

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_ctrl_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              frm_valid,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] wr_in,
    output logic [NUM_CH-1:0] upd_dac,
    output logic              pd_we,
    output logic              clr_we,
    output logic              mask_we,
    output logic              ref_we
);

    logic [NUM_CH-1:0] hit;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            hit[c] = (addr == ADDR_ALL) || (addr == ADDR_W'(c));
    end

    always_comb begin
        wr_in   = '0;
        upd_dac = '0;
        pd_we   = 1'b0;
        clr_we  = 1'b0;
        mask_we = 1'b0;
        ref_we  = 1'b0;
        if (frm_valid) begin
            case (op)
                OP_WRITE_IN:  wr_in = hit;
                OP_UPDATE:    upd_dac = hit;
                OP_WRITE_ALL: begin
                    wr_in   = hit;
                    upd_dac = '1;
                end
                OP_WRITE_UPD: begin
                    wr_in   = hit;
                    upd_dac = hit;
                end
                OP_POWER:     pd_we   = 1'b1;
                OP_CLEAR_SEL: clr_we  = 1'b1;
                OP_LOAD_MASK: mask_we = 1'b1;
                OP_REFERENCE: ref_we  = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dac_channel.sv
module dac_channel
    import dac_ctrl_pkg::*;
#(
    parameter bit WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_in,
    input  logic              upd_dac,
    input  logic              load_en,
    input  logic              clr_act,
    input  clr_sel_e          clr_sel,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code
);

    localparam int RES = WIDE ? CODE_W : NARROW_W;

    logic [RES-1:0]    in_r;
    logic [RES-1:0]    dac_r;
    logic [RES-1:0]    in_nxt;
    logic [RES-1:0]    clr_val;
    logic [CODE_W-1:0] clr_full;

    assign clr_full = clear_value(clr_sel, WIDE);
    assign clr_val  = clr_full[RES-1:0];
    assign in_nxt   = wr_in ? wr_data[CODE_W-1 -: RES] : in_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_r  <= '0;
            dac_r <= '0;
        end else begin
            in_r <= in_nxt;
            if (clr_act)
                dac_r <= clr_val;
            else if (upd_dac)
                dac_r <= in_nxt;
            else if (load_en)
                dac_r <= in_r;
        end
    end

    always_comb begin
        code          = '0;
        code[RES-1:0] = dac_r;
    end

    generate
        if (!WIDE) begin : g_narrow_sink
            logic unused_low;
            assign unused_low = ^{wr_data[CODE_W-RES-1:0], clr_full[CODE_W-1:RES]};
        end
    endgenerate

endmodule

// File: rtl/octal_dac_ctrl.sv
module octal_dac_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_WIDE = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sck,
    input  logic                     cs_n,
    input  logic                     sdi,
    input  logic                     hw_load_n,
    input  logic                     clear_n,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH*PD_W-1:0]   pd_mode,
    output logic                     ref_en
);

    localparam int PD_BUS_W = NUM_CH * PD_W;

    logic              frm_valid;
    frame_t            frm;
    logic [NUM_CH-1:0] wr_in;
    logic [NUM_CH-1:0] upd_dac;
    logic              pd_we;
    logic              clr_we;
    logic              mask_we;
    logic              ref_we;
    logic              load_act;
    logic              clr_act;
    logic [NUM_CH-1:0] mask_r;
    clr_sel_e          clr_sel_r;
    logic [PD_BUS_W-1:0] pd_r;
    logic              ref_r;
    logic              unused_pad;

    assign unused_pad = ^{frm.pad_hi, frm.pad_lo};

    dac_serial_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .frm_valid (frm_valid),
        .frm       (frm)
    );

    dac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .frm_valid (frm_valid),
        .op        (frm.op),
        .addr      (frm.addr),
        .wr_in     (wr_in),
        .upd_dac   (upd_dac),
        .pd_we     (pd_we),
        .clr_we    (clr_we),
        .mask_we   (mask_we),
        .ref_we    (ref_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_act  <= 1'b0;
            clr_act   <= 1'b0;
            mask_r    <= '1;
            clr_sel_r <= CLR_ZERO;
            pd_r      <= '0;
            ref_r     <= 1'b0;
        end else begin
            load_act <= ~hw_load_n;
            clr_act  <= ~clear_n;
            if (mask_we) mask_r    <= frm.data[NUM_CH-1:0];
            if (clr_we)  clr_sel_r <= clr_sel_e'(frm.data[1:0]);
            if (pd_we)   pd_r      <= frm.data[PD_BUS_W-1:0];
            if (ref_we)  ref_r     <= frm.data[0];
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            dac_channel #(.WIDE(g < NUM_WIDE)) u_ch (
                .clk     (clk),
                .rst     (rst),
                .wr_in   (wr_in[g]),
                .upd_dac (upd_dac[g]),
                .load_en (load_act & mask_r[g]),
                .clr_act (clr_act),
                .clr_sel (clr_sel_r),
                .wr_data (frm.data),
                .code    (dac_code[g*CODE_W +: CODE_W])
            );
        end
    endgenerate

    assign pd_mode = pd_r;
    assign ref_en  = ref_r;

endmodule

// File: rtl/dac_ctrl_chk.sv
module dac_ctrl_chk
    import dac_ctrl_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_WIDE = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH*PD_W-1:0]   pd_mode,
    input logic                     ref_en,
    input logic                     frm_valid,
    input logic                     load_act,
    input logic                     clr_act
);

    logic uniform;

    always_comb begin
        uniform = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c < NUM_WIDE) begin
                if (dac_code[c*CODE_W +: CODE_W] != dac_code[CODE_W-1:0])
                    uniform = 1'b0;
            end else begin
                if (dac_code[c*CODE_W +: CODE_W] != {4'h0, dac_code[CODE_W-1:4]})
                    uniform = 1'b0;
            end
        end
    end

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && pd_mode == '0 && !ref_en));

    // R10
    a_r10_ref_by_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_en) |-> $past(frm_valid));

    // R9
    a_r9_pd_by_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(pd_mode) |-> $past(frm_valid));

    // R8
    a_r8_clear_uniform: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> uniform);

    // R3, R7, R8, R12
    a_r12_code_has_cause: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_code) |-> ($past(frm_valid) || $past(load_act) || $past(clr_act)));

endmodule

bind octal_dac_ctrl dac_ctrl_chk #(.NUM_CH(NUM_CH), .NUM_WIDE(NUM_WIDE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode),
    .ref_en    (ref_en),
    .frm_valid (frm_valid),
    .load_act  (load_act),
    .clr_act   (clr_act)
);

// File: tb/sim_octal_dac_ctrl.sv
module sim_octal_dac_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sck = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdi = 1'b0;
    logic         hw_load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [127:0] dac_code;
    logic [15:0]  pd_mode;
    logic         ref_en;

    int    nchk = 0;
    int    nerr = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // behavioural reference state
    int m_in[8];
    int m_dac[8];
    int m_mask, m_clrsel, m_pd, m_ref;
    int pend_word = 0;
    int pend_bits = 0;
    bit s_cs1 = 1'b1, s_cs2 = 1'b1, s_ld1 = 1'b0, s_clr1 = 1'b0;

    always #2 clk = ~clk;

    octal_dac_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .hw_load_n (hw_load_n),
        .clear_n   (clear_n),
        .dac_code  (dac_code),
        .pd_mode   (pd_mode),
        .ref_en    (ref_en)
    );

    function automatic int clr_code(int sel, int c);
        if (sel == 1) return (c < 4) ? 'h8000 : 'h800;
        if (sel == 2) return (c < 4) ? 'hFFFF : 'hFFF;
        return 0;
    endfunction

    always @(posedge clk) begin
        int nin[8];
        bit upd[8];
        int op, ad, dat;
        bit fire;
        if (rst) begin
            for (int c = 0; c < 8; c++) begin
                m_in[c] = 0;
                m_dac[c] = 0;
            end
            m_mask = 'hFF; m_clrsel = 0; m_pd = 0; m_ref = 0;
        end else begin
            fire = s_cs1 && !s_cs2 && (pend_bits == 32);
            op  = (pend_word >> 24) & 'hF;
            ad  = (pend_word >> 20) & 'hF;
            dat = (pend_word >> 4) & 'hFFFF;
            for (int c = 0; c < 8; c++) begin
                nin[c] = m_in[c];
                upd[c] = 1'b0;
            end
            if (fire) begin
                for (int c = 0; c < 8; c++) begin
                    bit hit;
                    int v;
                    hit = (ad == 15) || (ad == c);
                    v = (c < 4) ? dat : (dat >> 4);
                    if (hit && (op == 0 || op == 2 || op == 3)) nin[c] = v;
                    if (hit && (op == 1 || op == 3)) upd[c] = 1'b1;
                    if (op == 2) upd[c] = 1'b1;
                end
            end
            for (int c = 0; c < 8; c++) begin
                if (s_clr1) m_dac[c] = clr_code(m_clrsel, c);
                else if (upd[c]) m_dac[c] = nin[c];
                else if (s_ld1 && ((m_mask >> c) & 1)) m_dac[c] = m_in[c];
            end
            for (int c = 0; c < 8; c++) m_in[c] = nin[c];
            if (fire && op == 4) m_pd = dat;
            if (fire && op == 5) m_clrsel = dat & 3;
            if (fire && op == 6) m_mask = dat & 'hFF;
            if (fire && op == 7) m_ref = dat & 1;
        end
        s_cs2 = s_cs1;
        s_cs1 = cs_n;
        s_ld1 = !hw_load_n;
        s_clr1 = !clear_n;
        cmp_on = 1'b1;
    end

    // every-cycle comparison against the reference model
    always @(negedge clk) begin
        if (cmp_on) begin
            bit bad;
            bad = 1'b0;
            nchk++;
            for (int c = 0; c < 8; c++) begin
                if (int'(dac_code[c*16 +: 16]) != m_dac[c]) begin
                    $display("FAIL %s ch%0d code actual=%h expected=%h", cur_req, c,
                             dac_code[c*16 +: 16], m_dac[c]);
                    bad = 1'b1;
                end
            end
            if (int'(pd_mode) != m_pd) begin
                $display("FAIL %s pd_mode actual=%h expected=%h", cur_req, pd_mode, m_pd);
                bad = 1'b1;
            end
            if (int'(ref_en) != m_ref) begin
                $display("FAIL %s ref_en actual=%0d expected=%0d", cur_req, ref_en, m_ref);
                bad = 1'b1;
            end
            if (bad) nerr++;
        end
    end

    task automatic hard(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ch(int c);
        return int'(dac_code[c*16 +: 16]);
    endfunction

    task automatic send(int op, int ad, int dat, int nb = 32);
        int w;
        w = ((op & 'hF) << 24) | ((ad & 'hF) << 20) | ((dat & 'hFFFF) << 4);
        @(negedge clk);
        pend_word = w;
        pend_bits = nb;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sdi = (i < 32) ? w[31 - i] : 1'b0;
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        hw_load_n = 1'b0;
        repeat (3) @(negedge clk);
        hw_load_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        nerr++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        cur_req = "R1";
        hard("R1 code", ch(0) | ch(7), 0);
        hard("R1 ref", int'(ref_en), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        hard("R1 after release", int'(pd_mode), 0);

        cur_req = "R3";
        send(0, 1, 'h1234);
        hard("R3 write input holds output", ch(1), 0);
        send(1, 1, 0);
        hard("R3 update", ch(1), 'h1234);

        cur_req = "R6";
        send(3, 5, 'hABCD);
        hard("R6 narrow slice", ch(5), 'h0ABC);

        cur_req = "R4";
        send(2, 0, 'h5555);
        hard("R4 write all ch0", ch(0), 'h5555);
        hard("R4 write all ch1", ch(1), 'h1234);

        cur_req = "R5";
        send(3, 15, 'h8001);
        hard("R5 broadcast wide", ch(3), 'h8001);
        hard("R5 broadcast narrow", ch(7), 'h0800);
        send(3, 9, 'h1111);
        hard("R5 reserved address", ch(0), 'h8001);

        cur_req = "R2";
        send(3, 2, 'h7777, 31);
        hard("R2 short frame", ch(2), 'h8001);
        send(3, 2, 'h7777, 33);
        hard("R2 long frame", ch(2), 'h8001);
        send(3, 2, 'h7777);
        hard("R2 exact frame", ch(2), 'h7777);

        cur_req = "R11";
        send(9, 2, 'h1111);
        send(15, 2, 'h2222);
        hard("R11 undefined ops", ch(2), 'h7777);

        cur_req = "R9";
        send(4, 0, 'hE41B);
        hard("R9 power modes", int'(pd_mode), 'hE41B);

        cur_req = "R10";
        send(7, 0, 1);
        hard("R10 ref on", int'(ref_en), 1);
        send(7, 0, 0);
        hard("R10 ref off", int'(ref_en), 0);

        cur_req = "R7";
        send(6, 0, 'h000F);
        send(0, 15, 'h2222);
        hard("R7 inputs pending", ch(0), 'h8001);
        pulse_load();
        hard("R7 masked-in channel", ch(0), 'h2222);
        hard("R7 masked-out channel", ch(4), 'h0800);
        send(6, 0, 'h00FF);
        send(0, 6, 'h3333);
        pulse_load();
        hard("R7 full mask", ch(6), 'h0333);

        cur_req = "R12";
        send(5, 0, 1);
        @(negedge clk);
        clear_n = 1'b0;
        @(negedge clk);
        hard("R12 one edge no change", ch(0), 'h2222);
        @(negedge clk);
        hard("R12 two edges cleared", ch(0), 'h8000);
        cur_req = "R8";
        hard("R8 midscale narrow", ch(4), 'h0800);
        @(negedge clk);
        clear_n = 1'b1;
        repeat (3) @(negedge clk);
        hard("R8 held after release", ch(1), 'h8000);
        send(5, 0, 2);
        pulse_clear();
        hard("R8 full wide", ch(2), 'hFFFF);
        hard("R8 full narrow", ch(5), 'h0FFF);
        send(5, 0, 3);
        pulse_clear();
        hard("R8 code 3 zero", ch(3) | ch(6), 0);
        send(1, 15, 0);
        hard("R8 inputs untouched wide", ch(0), 'h2222);
        hard("R8 inputs untouched narrow", ch(6), 'h0333);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
        $finish;
    end

endmodule